// File: doc/BRIEF.md
# Bus-Idle Reset Gate for a Hot-Insertable Bus Interface

This block sits between the bus interface engine of a hot-insertable board and the shared parallel bus. It holds the engine's state machines in idle while reset is active, and it keeps every bus driver in high impedance during reset. When reset ends, the interface is not let loose at once. The gate first watches the bus until it has seen a run of clock edges with no transaction in progress. A card inserted while other agents are mid-transfer therefore never joins a cycle that is already under way.

The raw active-low reset is asserted asynchronously and released through a two-flop synchronizer. Only the synchronized release starts the idle watch. The bus counts as idle on a rising edge where the cycle-framing strobe (`frame_n`) and the initiator-ready strobe (`irdy_n`) are both sampled high. Once the gate opens, it stays open until the next reset. The engine asks for its drivers through `drv_req`. The gate passes that request to `drv_oe` only while the interface is enabled, so the end of reset alone never turns a driver on.

Top module: `hsw_idle_gate`

## Requirements
- R1: Whenever `rst_n` is low, `drv_oe` is low. This holds at once, with no clock edge needed.
- R2: Whenever `rst_n` is low, `if_en` is low. This holds at once, with no clock edge needed.
- R3: After `rst_n` rises, the first two rising clock edges never set `if_en`. The earliest edge that can set it is the third.
- R4: `if_en` rises only after `IDLE_MIN` consecutive eligible rising edges, counting from the third edge after release, on each of which `frame_n` = 1 and `irdy_n` = 1. It rises on the edge that completes the run.
- R5: If the bus is busy when reset is released (`frame_n` = 0 or `irdy_n` = 0), `if_en` stays low for as long as the bus stays busy.
- R6: An edge with `frame_n` = 0 or `irdy_n` = 0 before `if_en` is set restarts the idle run from zero. A low on `irdy_n` alone counts as busy.
- R7: Once `if_en` is high, it stays high whatever the bus does, until `rst_n` is next asserted.
- R8: `drv_oe` is high exactly when `if_en` is high and `drv_req` is high. While `if_en` is low, `drv_req` has no effect on `drv_oe`.
- R9: Before reset is released, the clock may be stopped or may toggle irregularly. Both outputs stay low throughout, and the first release after that behaves as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Raw active-low reset, asynchronous assertion |
| frame_n | input | 1 | Bus cycle-framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| drv_req | input | 1 | Request from the interface engine to drive the bus |
| drv_oe | output | 1 | Output enable for all bus drivers; 0 means high impedance |
| if_en | output | 1 | Interface permitted to leave idle; 0 holds its state machines idle |

## Verification
The bench releases reset while a transfer is still in progress. A gate that ignored the bus would open in the middle of that transfer. It interrupts an idle run with a single busy edge, including one where only `irdy_n` is low. A gate that did not restart its count would then open one or more cycles too early. The bench also releases reset onto an already idle bus and checks the exact opening edge. This catches a missing or extra synchronizer stage, which shows up as an off-by-one. Reset is dropped between clock edges, and the clock is stopped or glitched before release. A design that needed a clock to clear its state would leave `drv_oe` driving during reset.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic {
    HS_WAIT = 1'b0,
    HS_OPEN = 1'b1
  } hs_state_e;

  // bus carries no transaction when both strobes are deasserted (high)
  function automatic logic bus_quiet(input logic frame_n, input logic irdy_n);
    return frame_n & irdy_n;
  endfunction

  // true when the sample now arriving completes the required idle run
  function automatic logic run_complete(input int unsigned seen, input int unsigned need);
    return (seen + 1) >= need;
  endfunction

endpackage

// File: rtl/hsw_rst_sync.sv
module hsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/hsw_idle_detect.sv
module hsw_idle_detect (
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle
);
  import hsw_pkg::*;
  assign bus_idle = bus_quiet(frame_n, irdy_n);
endmodule

// File: rtl/hsw_gate_fsm.sv
module hsw_gate_fsm #(
  parameter int IDLE_MIN = 2
) (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic bus_idle,
  output logic open_now
);
  import hsw_pkg::*;
  localparam int CW = (IDLE_MIN < 2) ? 1 : $clog2(IDLE_MIN + 1);

  hs_state_e     state;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state   <= HS_WAIT;
      run_cnt <= '0;
    end else if (state == HS_WAIT) begin
      if (!bus_idle) begin
        run_cnt <= '0;
      end else if (run_complete(int'(run_cnt), IDLE_MIN)) begin
        state   <= HS_OPEN;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign open_now = (state == HS_OPEN);
endmodule

// File: rtl/hsw_idle_gate.sv
module hsw_idle_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_MIN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic drv_req,
  output logic drv_oe,
  output logic if_en
);
  logic rst_sync_n;
  logic bus_idle;
  logic open_now;

  hsw_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hsw_idle_detect u_det (
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .bus_idle (bus_idle)
  );

  hsw_gate_fsm #(.IDLE_MIN(IDLE_MIN)) u_fsm (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .bus_idle   (bus_idle),
    .open_now   (open_now)
  );

  assign if_en  = open_now;
  // raw reset also gates the enable so drivers float even before the chain clears
  assign drv_oe = rst_n & open_now & drv_req;
endmodule

// File: rtl/hsw_idle_gate_chk.sv
module hsw_idle_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_sync_n,
  input logic bus_idle,
  input logic drv_req,
  input logic drv_oe,
  input logic if_en
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_oe_float_r1: assert (!drv_oe);
      p_held_idle_r2: assert (!if_en);
    end
  end

  p_open_after_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_en) |-> $past(rst_sync_n));

  p_open_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_en) |-> $past(bus_idle));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(if_en) |-> if_en);

  p_oe_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> (if_en && drv_req));
endmodule

bind hsw_idle_gate hsw_idle_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .bus_idle   (bus_idle),
  .drv_req    (drv_req),
  .drv_oe     (drv_oe),
  .if_en      (if_en)
);

// File: tb/hsw_idle_gate_bench.sv
`timescale 1ns/1ps
module hsw_idle_gate_bench;
  localparam int IDLE_MIN = 2;

  logic gen_clk = 1'b0, glitch = 1'b0, clk_run = 1'b0;
  logic clk;
  logic rst_n = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, drv_req = 1'b0;
  logic drv_oe, if_en;
  int   n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R2";

  assign clk = gen_clk | glitch;
  always #2 if (clk_run) gen_clk = ~gen_clk;

  hsw_idle_gate #(.SYNC_STAGES(2), .IDLE_MIN(IDLE_MIN)) u_hsw_idle_gate (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .drv_req(drv_req), .drv_oe(drv_oe), .if_en(if_en)
  );

  // behavioural reference: edges since release, idle run, open flag
  int m_rel, m_run;
  bit m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_run = 0; m_en = 0;
    end else begin
      if (m_rel >= 2 && !m_en) begin
        if (frame_n && irdy_n) begin
          m_run++;
          if (m_run >= IDLE_MIN) m_en = 1;
        end else m_run = 0;
      end
      if (m_rel < 2) m_rel++;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("if_en", if_en, m_en);
    chk("drv_oe", drv_oe, rst_n & m_en & drv_req);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      summary();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic release_rst();
    @(posedge clk); #1; rst_n = 1'b1;
  endtask

  initial begin
    // R9: clock stopped, reset low, bus noisy, request high
    tag = "R9"; drv_req = 1'b1; frame_n = 1'b0;
    #5; chk("if_en stopped clk", if_en, 1'b0); chk("drv_oe stopped clk", drv_oe, 1'b0);
    for (int i = 0; i < 7; i++) begin
      glitch = 1'b1; #(1 + i % 3); glitch = 1'b0; #(1 + (i * 2) % 5);
      frame_n = ~frame_n;
    end
    chk("if_en after glitches", if_en, 1'b0); chk("drv_oe after glitches R1", drv_oe, 1'b0);
    clk_run = 1'b1;
    step(3);

    // R5: release mid-transfer, bus busy for a while
    tag = "R5"; frame_n = 1'b0; irdy_n = 1'b0;
    release_rst(); step(6);
    chk("held while busy", if_en, 1'b0);
    frame_n = 1'b1; step(2);
    chk("held through tail", if_en, 1'b0);
    tag = "R4"; irdy_n = 1'b1; step(1);
    chk("one idle edge not enough", if_en, 1'b0);
    step(1); #1;
    chk("open after idle run", if_en, 1'b1);

    // R7: bus activity after opening
    tag = "R7"; frame_n = 1'b0; irdy_n = 1'b0; step(4);
    chk("stays open", if_en, 1'b1);
    // R8: request passes through only when open
    tag = "R8"; drv_req = 1'b0; #1; chk("oe follows req low", drv_oe, 1'b0);
    drv_req = 1'b1; #1; chk("oe follows req high", drv_oe, 1'b1);
    frame_n = 1'b1; irdy_n = 1'b1; step(2);

    // R1/R2: asynchronous reset between edges
    tag = "R1/R2"; @(posedge clk); #1; rst_n = 1'b0; #0.5;
    chk("oe floats at once", drv_oe, 1'b0); chk("en drops at once", if_en, 1'b0);
    step(3);

    // R3: release on an idle bus, exact opening edge
    tag = "R3"; drv_req = 1'b1;
    release_rst(); step(2);
    chk("closed after two edges", if_en, 1'b0);
    step(IDLE_MIN); #1;
    chk("opens on completing edge", if_en, 1'b1);
    @(posedge clk); #1; rst_n = 1'b0; step(2);

    // R6: interrupted runs, irdy_n low alone is busy
    tag = "R6"; drv_req = 1'b0;
    release_rst(); step(2);
    step(1);
    irdy_n = 1'b0; step(1);
    irdy_n = 1'b1; step(1);
    chk("run restarted by irdy_n", if_en, 1'b0);
    frame_n = 1'b0; step(1); frame_n = 1'b1; step(1);
    chk("run restarted by frame_n", if_en, 1'b0);
    tag = "R8"; drv_req = 1'b1; #1; chk("req ignored while closed", drv_oe, 1'b0);
    tag = "R6"; step(1); #1;
    chk("open after full run", if_en, 1'b1);
    step(3);
    summary();
  end
endmodule